// File: doc/BRIEF.md
# Zero-Turnaround SRAM Host Controller

This controller sits on the master side of a flow-through synchronous SRAM that needs no idle cycle between writes and reads. Requests arrive on a valid/ready stream. Each request names a direction, a word address, write data and a byte mask. The controller turns each request into one command slot on the memory pins. A write's data and byte selects go onto the bus in the slot after its command. A read's data is captured at the clock edge that ends the slot after its command. Read data comes back on a response stream, in request order.

A request may ask for the next word of the current burst instead of a new address. The burst follows the memory's four-beat wrap order, which is either linear or XOR. When the memory's burst counter can still produce that address, the controller issues a continuation with the load strobe high. When it cannot, the controller loads the computed address as a fresh command. When no request is waiting, the controller issues a deselect. When a read's data is on the bus and the response holding register is still full, the controller raises the memory clock enable. The memory and the controller's pipeline then freeze together.

Top module: `zt_sram_host`

## Requirements
- R1: During and after reset, with no request waiting, the pins show a deselect: mem_ce1_n=1, mem_ce2=0, mem_ce3_n=1, mem_adv_ld=0, mem_we_n=1, mem_bw_n all ones, mem_dq_oe=0, mem_oe_n=0, mem_cen_n=0. In addition rsp_valid=0 and req_ready=1.
- R2: An accepted write that is not a continuation appears in the next slot as mem_adv_ld=0, mem_we_n=0 and chips selected, with mem_addr equal to the target address. In the slot after that, mem_dq_oe=1, mem_dq_o carries the data and mem_bw_n equals the inverted mask. A low bit i of mem_bw_n writes byte i, which is bits [8i+7:8i].
- R3: An accepted read appears as mem_adv_ld=0 and mem_we_n=1. The bus is captured at the edge that ends the following slot. rsp_valid rises in the slot after that capture. Responses leave in request order.
- R4: A stream of requests that mixes writes and reads is issued one command per slot, with no deselect slot between any two requests.
- R5: The controller drives the bus (mem_dq_oe=1) only in the data slot of its own write. mem_oe_n is high exactly in those slots and low in all others, so the two sides never drive the bus at the same time.
- R6: A slot with no accepted request carries a deselect: chips inactive, mem_adv_ld=0, mem_we_n=1.
- R7: A request with req_next=1 targets the next address in the current sequence: the upper bits are kept, and the low two bits are start+k (linear, order_xor=0) or start XOR k (order_xor=1), for beat k modulo 4. The request is issued with mem_adv_ld=1 when the previous slot carried an access in the same direction and fewer than four beats have been issued.
- R8: A req_next request is issued with mem_adv_ld=0 at its sequence address, and that address starts a new sequence, in three cases: after a deselect slot, after a change of direction, or once four beats have been issued.
- R9: In a burst write, each beat's own mask drives mem_bw_n in that beat's data slot.
- R10: mem_cen_n is high only when read data is on the bus and the response register is full and not taken. While it is high, req_ready is low, every pin is held and no response is lost.
- R11: While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_xor | input | 1 | Burst order of the memory: 0 linear, 1 XOR |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_next | input | 1 | Target the next address of the current sequence |
| req_addr | input | AW | Word address when req_next is 0 |
| req_wdata | input | DW | Write data |
| req_wmask | input | DW/8 | Byte write mask, active high |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DW | Read data |
| mem_addr | output | AW | Memory address |
| mem_adv_ld | output | 1 | 1 advance burst counter, 0 load |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bw_n | output | DW/8 | Byte selects, active low |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_ce3_n | output | 1 | Chip enable, active low |
| mem_cen_n | output | 1 | Clock enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_i | input | DW | Data bus as seen by the controller |

## Verification
The bench connects the controller to a small behavioural memory. The memory decodes the pins by itself, so a wrong strobe, address or slot turns into wrong read data. Writes and reads to the same addresses are interleaved with no gap, which shows whether the bus turns around without an idle slot and whether the memory returns freshly written data. Bursts start from unaligned addresses in both orders and then read back single words, which separates linear from XOR placement. Bursts broken by a deselect, a direction change or a fifth beat show whether the reload path is taken. A slow response consumer shows whether the clock-enable stall keeps every response in order.

// File: rtl/zt_sram_host.sv
module zt_sram_host #(
  parameter int AW = 19,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            order_xor,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_next,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_wmask,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_adv_ld,
  output logic            mem_we_n,
  output logic [DW/8-1:0] mem_bw_n,
  output logic            mem_ce1_n,
  output logic            mem_ce2,
  output logic            mem_ce3_n,
  output logic            mem_cen_n,
  output logic            mem_oe_n,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_i
);
  localparam int NB = DW / 8;
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_WR   = 2'd1;
  localparam logic [1:0] K_RD   = 2'd2;

  logic [1:0]    tag_a, tag_b, req_kind;
  logic [1:0]    seq_beat, nxt_beat, nxt_lo;
  logic [AW-1:0] seq_base, nxt_addr, tgt_addr;
  logic [DW-1:0] wdat_a;
  logic [NB-1:0] wmask_a;
  logic          sel, stall, fire, cont_ok;

  assign stall     = (tag_b == K_RD) && rsp_valid && !rsp_ready;
  assign mem_cen_n = stall;
  assign req_ready = !stall;
  assign fire      = req_valid && !stall;
  assign req_kind  = req_write ? K_WR : K_RD;

  assign nxt_beat = seq_beat + 2'd1;
  assign nxt_lo   = order_xor ? (seq_base[1:0] ^ nxt_beat) : (seq_base[1:0] + nxt_beat);
  assign nxt_addr = {seq_base[AW-1:2], nxt_lo};
  assign cont_ok  = req_next && (tag_a == req_kind) && (seq_beat != 2'd3);
  assign tgt_addr = req_next ? nxt_addr : req_addr;

  assign mem_ce1_n = !sel;
  assign mem_ce2   = sel;
  assign mem_ce3_n = !sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_a      <= K_NONE;
      sel        <= 1'b0;
      mem_adv_ld <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_addr   <= '0;
      wdat_a     <= '0;
      wmask_a    <= '0;
      seq_base   <= '0;
      seq_beat   <= 2'd0;
    end else if (!stall) begin
      if (fire) begin
        tag_a    <= req_kind;
        sel      <= 1'b1;
        mem_we_n <= !req_write;
        wdat_a   <= req_wdata;
        wmask_a  <= req_wmask;
        if (cont_ok) begin
          mem_adv_ld <= 1'b1;
          mem_addr   <= nxt_addr;
          seq_beat   <= nxt_beat;
        end else begin
          mem_adv_ld <= 1'b0;
          mem_addr   <= tgt_addr;
          seq_base   <= tgt_addr;
          seq_beat   <= 2'd0;
        end
      end else begin
        tag_a      <= K_NONE;
        sel        <= 1'b0;
        mem_adv_ld <= 1'b0;
        mem_we_n   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_b     <= K_NONE;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      mem_oe_n  <= 1'b0;
      mem_bw_n  <= '1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (!stall) begin
        tag_b     <= tag_a;
        mem_dq_o  <= wdat_a;
        mem_dq_oe <= (tag_a == K_WR);
        mem_oe_n  <= (tag_a == K_WR);
        mem_bw_n  <= (tag_a == K_WR) ? ~wmask_a : '1;
      end
      if (!stall && tag_b == K_RD) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem_dq_i;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R2
  wr_data_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cen_n && !mem_we_n && mem_ce2) |=> mem_dq_oe);

  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cen_n && (mem_we_n || !mem_ce2)) |=> !mem_dq_oe);

  // R5
  oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7
  burst_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_adv_ld && $past(!mem_cen_n)) |-> $past(mem_ce2));

  // R10
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cen_n |-> (rsp_valid && !rsp_ready));

  // R10
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cen_n |=> ($stable(mem_addr) && $stable(mem_adv_ld) && $stable(mem_we_n)
                   && $stable(mem_dq_o) && $stable(mem_dq_oe) && $stable(mem_bw_n)));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/zt_sram_host_bench.sv
module zt_sram_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic order_xor = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_next = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NB-1:0] req_wmask = '0;
  logic req_ready, rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic mem_adv_ld, mem_we_n, mem_ce1_n, mem_ce2, mem_ce3_n, mem_cen_n, mem_oe_n, mem_dq_oe;
  logic [NB-1:0] mem_bw_n;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  zt_sram_host #(.AW(AW), .DW(DW)) u_zt_sram_host (
    .clk(clk), .rst_n(rst_n), .order_xor(order_xor),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_next(req_next),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_adv_ld(mem_adv_ld), .mem_we_n(mem_we_n), .mem_bw_n(mem_bw_n),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_ce3_n(mem_ce3_n), .mem_cen_n(mem_cen_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  function automatic logic [1:0] seq_lo(input logic [1:0] s, input logic [1:0] k, input logic ox);
    return ox ? (s ^ k) : (s + k);
  endfunction

  // behavioural flow-through memory decoding the pins
  logic [DW-1:0] mdl_mem [DEPTH];
  logic m_act, m_dir_wr, m_pwr, m_prd;
  logic [AW-1:0] m_base, m_paddr;
  logic [1:0] m_beat;
  logic mem_sel, mem_drv;
  assign mem_sel = !mem_ce1_n && mem_ce2 && !mem_ce3_n;
  assign mem_drv = m_prd && !mem_oe_n;
  assign mem_dq_i = mem_drv ? mdl_mem[m_paddr] : 32'hBAD0_BAD0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0; m_dir_wr <= 1'b0; m_pwr <= 1'b0; m_prd <= 1'b0;
      m_base <= '0; m_paddr <= '0; m_beat <= 2'd0;
    end else if (!mem_cen_n) begin
      if (m_pwr)
        for (int b = 0; b < NB; b++)
          if (!mem_bw_n[b]) mdl_mem[m_paddr][8*b +: 8] <= mem_dq_o[8*b +: 8];
      m_pwr <= 1'b0;
      m_prd <= 1'b0;
      if (!mem_adv_ld) begin
        if (mem_sel) begin
          m_act <= 1'b1; m_dir_wr <= !mem_we_n; m_base <= mem_addr; m_beat <= 2'd0;
          m_paddr <= mem_addr; m_pwr <= !mem_we_n; m_prd <= mem_we_n;
        end else begin
          m_act <= 1'b0;
        end
      end else if (m_act) begin
        m_beat  <= m_beat + 2'd1;
        m_paddr <= {m_base[AW-1:2], seq_lo(m_base[1:0], m_beat + 2'd1, order_xor)};
        m_pwr   <= m_dir_wr;
        m_prd   <= !m_dir_wr;
      end
    end
  end

  // counters and monitors
  int n_chk = 0, n_fail = 0;
  int n_adv_hi = 0, n_load = 0, n_desel = 0, n_stall = 0, n_clash = 0;
  int n_stall_ready = 0, n_stall_move = 0, n_rsp_drop = 0, exp_adv_hi = 0;
  logic [DW-1:0] rsp_q[$];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] ref_mem [DEPTH];
  logic prv_stall = 1'b0, prv_hold = 1'b0;
  logic [AW-1:0] prv_addr = '0;
  logic [DW-1:0] prv_rsp = '0;

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (!mem_cen_n && mem_adv_ld) n_adv_hi++;
      if (!mem_cen_n && !mem_adv_ld && mem_sel) n_load++;
      if (!mem_cen_n && !mem_adv_ld && !mem_sel) n_desel++;
      if (mem_cen_n) n_stall++;
      if (mem_cen_n && req_ready) n_stall_ready++;
      if (mem_drv && mem_dq_oe) n_clash++;
      if (prv_stall && mem_addr != prv_addr) n_stall_move++;
      if (prv_hold && (!rsp_valid || rsp_data != prv_rsp)) n_rsp_drop++;
      if (rsp_valid && rsp_ready) rsp_q.push_back(rsp_data);
      prv_stall = mem_cen_n;
      prv_addr  = mem_addr;
      prv_hold  = rsp_valid && !rsp_ready;
      prv_rsp   = rsp_data;
    end
  end

  logic bp_mode = 1'b0;
  int bp_cnt = 0;
  always begin
    @(negedge clk);
    bp_cnt++;
    rsp_ready = bp_mode ? (bp_cnt % 3 == 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // bench-side sequence tracking
  logic [AW-1:0] b_base = '0;
  logic [1:0] b_beat = 2'd0;
  int b_prev = 0;

  task automatic put(input bit w, input bit nx, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [NB-1:0] m);
    logic [AW-1:0] t;
    logic [1:0] nb;
    bit cont;
    int kind;
    kind = w ? 1 : 2;
    if (nx) begin
      nb = b_beat + 2'd1;
      t = {b_base[AW-1:2], seq_lo(b_base[1:0], nb, order_xor)};
      cont = (b_prev == kind) && (b_beat != 2'd3);
    end else begin
      nb = 2'd0;
      t = a;
      cont = 1'b0;
    end
    if (cont) begin b_beat = nb; exp_adv_hi++; end
    else begin b_base = t; b_beat = 2'd0; end
    b_prev = kind;
    if (w) begin
      for (int b = 0; b < NB; b++) if (m[b]) ref_mem[t][8*b +: 8] = d[8*b +: 8];
    end else begin
      exp_q.push_back(ref_mem[t]);
    end
    req_valid = 1'b1; req_write = w; req_next = nx; req_addr = a; req_wdata = d; req_wmask = m;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    bit seen;
    seen = 1'b0;
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (req_ready) seen = 1'b1;
      @(negedge clk); #2;
    end
    if (seen) b_prev = 0;
  endtask

  task automatic drain(input string tag);
    int guard;
    guard = 0;
    while (rsp_q.size() < exp_q.size() && guard < 300) begin idle(1); guard++; end
    idle(2);
    chk(rsp_q.size() == exp_q.size(), {tag, " response count"}, rsp_q.size(), exp_q.size());
    while (exp_q.size() > 0 && rsp_q.size() > 0) begin
      logic [DW-1:0] e, r;
      e = exp_q.pop_front();
      r = rsp_q.pop_front();
      chk(r == e, {tag, " response data in order"}, r, e);
    end
    exp_q.delete();
    rsp_q.delete();
  endtask

  task automatic t_reset();
    chk({mem_ce1_n, mem_ce2, mem_ce3_n, mem_adv_ld, mem_we_n, mem_dq_oe, mem_oe_n,
         mem_cen_n, rsp_valid, req_ready} == 10'b1010100001, "R1 reset pins",
        {mem_ce1_n, mem_ce2, mem_ce3_n, mem_adv_ld, mem_we_n, mem_dq_oe, mem_oe_n,
         mem_cen_n, rsp_valid, req_ready}, 10'b1010100001);
    chk(mem_bw_n == '1, "R1 reset byte selects", mem_bw_n, 4'hF);
  endtask

  task automatic t_write_timing();
    put(1, 0, 8'h05, 32'hA1B2C3D4, 4'b0101);
    chk(!mem_adv_ld && !mem_we_n && mem_sel && mem_addr == 8'h05, "R2 write command slot",
        {mem_adv_ld, mem_we_n, mem_sel, mem_addr}, {3'b001, 8'h05});
    idle(1);
    chk(mem_dq_oe && mem_oe_n, "R2 R5 write data slot drive", {mem_dq_oe, mem_oe_n}, 2'b11);
    chk(mem_dq_o == 32'hA1B2C3D4, "R2 write data", mem_dq_o, 32'hA1B2C3D4);
    chk(mem_bw_n == 4'b1010, "R2 byte selects", mem_bw_n, 4'b1010);
    idle(1);
    chk(!mem_dq_oe && !mem_oe_n, "R5 bus released", {mem_dq_oe, mem_oe_n}, 2'b00);
    chk(!mem_sel && !mem_adv_ld && mem_we_n, "R6 deselect when empty",
        {mem_sel, mem_adv_ld, mem_we_n}, 3'b001);
  endtask

  task automatic t_read_timing();
    put(0, 0, 8'h05, '0, '0);
    chk(!mem_adv_ld && mem_we_n && mem_sel, "R3 read command slot",
        {mem_adv_ld, mem_we_n, mem_sel}, 3'b011);
    idle(1);
    chk(!rsp_valid, "R3 no response before capture edge", rsp_valid, 1'b0);
    idle(1);
    chk(rsp_valid && rsp_data == 32'h00B200D4, "R3 captured read data",
        {31'd0, rsp_valid, rsp_data}, {31'd1, 32'h00B200D4});
    drain("R3");
  endtask

  task automatic t_turnaround();
    int d0, l0;
    d0 = n_desel; l0 = n_load;
    for (int i = 0; i < 4; i++) begin
      put(1, 0, 8'h60 + 8'(i), 32'h1111_0000 + 32'(i * 7), 4'hF);
      put(0, 0, 8'h60 + 8'(i), '0, '0);
    end
    chk(n_desel == d0, "R4 no idle slot in mixed stream", n_desel - d0, 0);
    chk(n_load - l0 == 8, "R4 one command per request", n_load - l0, 8);
    idle(2);
    drain("R4");
    chk(n_clash == 0, "R5 no bus contention", n_clash, 0);
  endtask

  task automatic t_burst_linear();
    order_xor = 1'b0;
    put(1, 0, 8'h12, 32'hC0DE_0000, 4'hF);
    put(1, 1, '0, 32'hC0DE_0001, 4'hF);
    put(1, 1, '0, 32'hC0DE_0002, 4'hF);
    put(1, 1, '0, 32'hC0DE_0003, 4'hF);
    put(0, 0, 8'h12, '0, '0);
    put(0, 1, '0, '0, '0);
    put(0, 1, '0, '0, '0);
    put(0, 1, '0, '0, '0);
    for (int i = 0; i < 4; i++) put(0, 0, 8'h10 + 8'(i), '0, '0);
    idle(2);
    drain("R7 linear");
    chk(n_adv_hi == exp_adv_hi, "R7 linear continuation count", n_adv_hi, exp_adv_hi);
  endtask

  task automatic t_burst_xor();
    order_xor = 1'b1;
    idle(1);
    put(1, 0, 8'h21, 32'hAAAA_AAAA, 4'b0001);
    put(1, 1, '0, 32'hBBBB_BBBB, 4'b0010);
    put(1, 1, '0, 32'hCCCC_CCCC, 4'b0100);
    put(1, 1, '0, 32'hDDDD_DDDD, 4'b1000);
    for (int i = 0; i < 4; i++) put(0, 0, 8'h20 + 8'(i), '0, '0);
    put(0, 0, 8'h23, '0, '0);
    put(0, 1, '0, '0, '0);
    put(0, 1, '0, '0, '0);
    put(0, 1, '0, '0, '0);
    idle(2);
    drain("R7 R9 xor");
    chk(n_adv_hi == exp_adv_hi, "R7 xor continuation count", n_adv_hi, exp_adv_hi);
    order_xor = 1'b0;
    idle(1);
  endtask

  task automatic t_reload();
    int l0;
    l0 = n_load;
    put(1, 0, 8'h30, 32'h3000_0000, 4'hF);
    for (int i = 1; i < 5; i++) put(1, 1, '0, 32'h3000_0000 + 32'(i), 4'hF);
    chk(n_load - l0 == 2, "R8 fifth beat reloads", n_load - l0, 2);
    put(1, 0, 8'h40, 32'h4000_0000, 4'hF);
    put(1, 1, '0, 32'h4000_0001, 4'hF);
    idle(2);
    l0 = n_load;
    put(1, 1, '0, 32'h4000_0002, 4'hF);
    chk(!mem_adv_ld && mem_addr == 8'h42, "R8 reload after deselect",
        {mem_adv_ld, mem_addr}, {1'b0, 8'h42});
    put(0, 1, '0, '0, '0);
    chk(!mem_adv_ld && mem_addr == 8'h43, "R8 reload after direction change",
        {mem_adv_ld, mem_addr}, {1'b0, 8'h43});
    chk(n_load - l0 == 2, "R8 reload commands", n_load - l0, 2);
    for (int i = 0; i < 4; i++) put(0, 0, 8'h30 + 8'(i), '0, '0);
    for (int i = 0; i < 4; i++) put(0, 0, 8'h40 + 8'(i), '0, '0);
    idle(2);
    drain("R8");
    chk(n_adv_hi == exp_adv_hi, "R8 continuation count", n_adv_hi, exp_adv_hi);
  endtask

  task automatic t_backpressure();
    bp_mode = 1'b1;
    put(0, 0, 8'h60, '0, '0);
    put(0, 0, 8'h61, '0, '0);
    put(0, 0, 8'h12, '0, '0);
    put(1, 0, 8'h62, 32'h5EED_0062, 4'b0011);
    put(0, 0, 8'h62, '0, '0);
    put(0, 0, 8'h63, '0, '0);
    put(0, 0, 8'h21, '0, '0);
    put(0, 1, '0, '0, '0);
    drain("R10 R11");
    bp_mode = 1'b0;
    idle(2);
    chk(n_stall > 0, "R10 clock enable raised", n_stall, 1);
    chk(n_stall_ready == 0, "R10 no request taken in stall", n_stall_ready, 0);
    chk(n_stall_move == 0, "R10 pins frozen in stall", n_stall_move, 0);
    chk(n_rsp_drop == 0, "R11 held response stable", n_rsp_drop, 0);
    chk(n_clash == 0, "R5 no contention under stall", n_clash, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mdl_mem[i] = '0;
      ref_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_write_timing();
    t_read_timing();
    t_turnaround();
    t_burst_linear();
    t_burst_xor();
    t_reload();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule